// File: doc/BRIEF.md
# Wakeup-Select Issue Logic

This block is the select half of an out-of-order issue stage. Entry storage and the wakeup comparators sit outside it. Each cycle it receives a ready vector from wakeup, with one bit per reservation-station entry, telling it which entries hold all their operands. It also receives a dispatch sequence number for every entry, a head pointer for every bank, and a busy flag for every execution port. From these it decides which entries go to execution. The result is registered, and each port gets a valid bit and a one-hot grant vector over all entries.

A single parameter fixes how the entries are organised:

- **Unified:** one selector hands up to `PORTS` of the `ENTRIES` entries to the free ports.
- **Banked:** the entries are divided into `PORTS` equal banks, with one bank per port. Each bank picks one of its own entries.
- **Head-only:** each bank is a FIFO, and only the entry under its head pointer can issue, so there is no search at all.

In every organisation the oldest ready entry wins, and a port whose unit is busy receives nothing.

Top module: `issueSelect`

## Requirements
- R1: While `rstN` is low, and after any rising edge sampled with `rstN` low, `grantValid` and `grantVec` are all zero.
- R2: The grants are registered. The outputs after rising edge k reflect the inputs sampled at edge k, and a change of inputs between edges leaves the outputs unchanged.
- R3: For port p, the slice `grantVec[p*ENTRIES +: ENTRIES]` has at most one bit set, with bit e meaning entry e. `grantValid[p]` is 1 exactly when that slice is nonzero.
- R4: No entry is granted to more than one port in a cycle, and only entries whose `readyVec` bit was 1 are granted.
- R5: A port whose `unitBusy` bit was 1 at the sampling edge gets no grant. Entries that can only go to that port are held back.
- R6: Unified organisation (`ORG_UNIFIED`): age is the entry's `AGE_W`-bit field e of `ageFlat`, and a smaller value means older. Among equal ages, the lower index counts as older. The oldest ready entry goes to the lowest-numbered free port, the next oldest goes to the next free port, and so on, until either the ready entries or the free ports run out.
- R7: Banked organisation (`ORG_BANKED`): bank b holds entries `b*BANK` to `b*BANK+BANK-1`, where `BANK = ENTRIES/PORTS`. Port b grants the oldest ready entry of bank b under the age rule of R6, and never grants an entry outside bank b.
- R8: Head-only organisation (`ORG_FIFO`): port b grants entry `b*BANK + h`, where h is field b of `headFlat` (`HEAD_W` bits wide), only if that entry is ready. Other ready entries of the bank are never granted.
- R9: When fewer entries are eligible than there are free ports, the surplus ports drive `grantValid` low. The number of valid ports never exceeds the number of ready entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| readyVec | input | ENTRIES | Woken entries, one bit per entry |
| ageFlat | input | ENTRIES*AGE_W | Dispatch sequence number per entry, smaller is older |
| headFlat | input | PORTS*HEAD_W | Head offset within each bank (head-only organisation) |
| unitBusy | input | PORTS | Execution unit behind each port cannot accept work |
| grantValid | output | PORTS | Port carries a grant this cycle |
| grantVec | output | PORTS*ENTRIES | One-hot grant per port over all entries |

## Verification
Every grant is due one rising edge after the inputs that cause it, because the selection is combinational and a single output register follows it. The bench therefore changes its inputs on the falling edge and compares all three organisations 1 ns after the next rising edge, against models that work from the requirements. To check R2, the bench also samples the outputs between a falling-edge input change and the following rising edge, where they must still show the previous result. To check R1, it samples during reset, after an edge at which every entry was ready.

// File: rtl/issuePkg.sv
package issuePkg;

  typedef enum logic [1:0] {
    ORG_UNIFIED = 2'd0,
    ORG_BANKED  = 2'd1,
    ORG_FIFO    = 2'd2
  } issueOrg_e;

  // Default shape of the control-to-datapath strobe bundle.
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_PORTS   = 2;

  typedef struct packed {
    logic [DEF_PORTS-1:0]             pickValid;
    logic [DEF_PORTS*DEF_ENTRIES-1:0] pickVec;
  } issueStrobeDef_t;

endpackage

// File: rtl/issueAgeMatrix.sv
// Pairwise age relation: olderMat[i*ENTRIES+j] set when entry i is older than j.
module issueAgeMatrix #(
  parameter int ENTRIES = 8,
  parameter int AGE_W   = 4
) (
  input  logic [ENTRIES*AGE_W-1:0]   ageFlat,
  output logic [ENTRIES*ENTRIES-1:0] olderMat
);

  for (genvar i = 0; i < ENTRIES; i++) begin : gRow
    for (genvar j = 0; j < ENTRIES; j++) begin : gCol
      if (i == j) begin : gSelf
        assign olderMat[i*ENTRIES+j] = 1'b0;
      end else if (i < j) begin : gLowIdx
        // Equal age: the lower index counts as older.
        assign olderMat[i*ENTRIES+j] =
          ageFlat[i*AGE_W +: AGE_W] <= ageFlat[j*AGE_W +: AGE_W];
      end else begin : gHighIdx
        assign olderMat[i*ENTRIES+j] =
          ageFlat[i*AGE_W +: AGE_W] < ageFlat[j*AGE_W +: AGE_W];
      end
    end
  end

endmodule

// File: rtl/issueSelectCtrl.sv
// Selection control: one of three organisations picked by ORG.
module issueSelectCtrl
  import issuePkg::*;
#(
  parameter int        ENTRIES  = 8,
  parameter int        PORTS    = 2,
  parameter int        HEAD_W   = 2,
  parameter issueOrg_e ORG      = ORG_UNIFIED,
  parameter type       strobe_t = issueStrobeDef_t
) (
  input  logic [ENTRIES-1:0]         readyVec,
  input  logic [ENTRIES*ENTRIES-1:0] olderMat,
  input  logic [PORTS*HEAD_W-1:0]    headFlat,
  input  logic [PORTS-1:0]           unitBusy,
  output strobe_t                    strobe
);

  localparam int BANK   = ENTRIES / PORTS;
  localparam int RANK_W = $clog2(ENTRIES + 1);

  logic [PORTS*ENTRIES-1:0] pick;
  logic                     unusedInputs;

  if (ORG == ORG_UNIFIED) begin : gUnified
    // Rank of each ready entry among ready entries; port rank among free ports.
    logic [RANK_W-1:0] rank     [ENTRIES];
    logic [RANK_W-1:0] freeRank [PORTS];

    assign unusedInputs = ^headFlat;

    always_comb begin
      for (int e = 0; e < ENTRIES; e++) begin
        rank[e] = '0;
        for (int j = 0; j < ENTRIES; j++) begin
          if (readyVec[j] && olderMat[j*ENTRIES+e]) begin
            rank[e] = rank[e] + RANK_W'(1);
          end
        end
      end
      for (int p = 0; p < PORTS; p++) begin
        freeRank[p] = '0;
        for (int q = 0; q < p; q++) begin
          if (!unitBusy[q]) begin
            freeRank[p] = freeRank[p] + RANK_W'(1);
          end
        end
      end
      for (int p = 0; p < PORTS; p++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          pick[p*ENTRIES+e] = readyVec[e] && !unitBusy[p] && (rank[e] == freeRank[p]);
        end
      end
    end

  end else if (ORG == ORG_BANKED) begin : gBanked
    assign unusedInputs = ^headFlat;

    always_comb begin
      logic win;
      pick = '0;
      for (int b = 0; b < PORTS; b++) begin
        for (int k = 0; k < BANK; k++) begin
          win = readyVec[b*BANK+k] && !unitBusy[b];
          for (int m = 0; m < BANK; m++) begin
            if (readyVec[b*BANK+m] && olderMat[(b*BANK+m)*ENTRIES + b*BANK + k]) begin
              win = 1'b0;
            end
          end
          pick[b*ENTRIES + b*BANK + k] = win;
        end
      end
    end

  end else begin : gFifo
    assign unusedInputs = ^olderMat;

    always_comb begin
      int hIdx;
      pick = '0;
      for (int b = 0; b < PORTS; b++) begin
        hIdx = b*BANK + int'(headFlat[b*HEAD_W +: HEAD_W]);
        pick[b*ENTRIES + hIdx] = readyVec[hIdx] && !unitBusy[b];
      end
    end
  end

  always_comb begin
    strobe.pickVec = pick;
    for (int p = 0; p < PORTS; p++) begin
      strobe.pickValid[p] = |pick[p*ENTRIES +: ENTRIES];
    end
  end

endmodule

// File: rtl/issueGrantReg.sv
// Issue-stage register: captures the strobes into the port outputs.
module issueGrantReg
  import issuePkg::*;
#(
  parameter int  ENTRIES  = 8,
  parameter int  PORTS    = 2,
  parameter type strobe_t = issueStrobeDef_t
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  output logic [PORTS-1:0]         grantValid,
  output logic [PORTS*ENTRIES-1:0] grantVec
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= '0;
      grantVec   <= '0;
    end else begin
      grantValid <= strobe.pickValid;
      grantVec   <= strobe.pickVec;
    end
  end

endmodule

// File: rtl/issueSelect.sv
module issueSelect
  import issuePkg::*;
#(
  parameter int        ENTRIES = 8,
  parameter int        PORTS   = 2,
  parameter int        AGE_W   = 4,
  parameter issueOrg_e ORG     = ORG_UNIFIED,
  localparam int       BANK    = ENTRIES / PORTS,
  localparam int       HEAD_W  = (BANK > 1) ? $clog2(BANK) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ENTRIES-1:0]       readyVec,
  input  logic [ENTRIES*AGE_W-1:0] ageFlat,
  input  logic [PORTS*HEAD_W-1:0]  headFlat,
  input  logic [PORTS-1:0]         unitBusy,
  output logic [PORTS-1:0]         grantValid,
  output logic [PORTS*ENTRIES-1:0] grantVec
);

  typedef struct packed {
    logic [PORTS-1:0]         pickValid;
    logic [PORTS*ENTRIES-1:0] pickVec;
  } strobe_t;

  logic [ENTRIES*ENTRIES-1:0] olderMat;
  strobe_t                    strobe;

  issueAgeMatrix #(
    .ENTRIES (ENTRIES),
    .AGE_W   (AGE_W)
  ) ageMat_i (
    .ageFlat  (ageFlat),
    .olderMat (olderMat)
  );

  issueSelectCtrl #(
    .ENTRIES  (ENTRIES),
    .PORTS    (PORTS),
    .HEAD_W   (HEAD_W),
    .ORG      (ORG),
    .strobe_t (strobe_t)
  ) ctrl_i (
    .readyVec (readyVec),
    .olderMat (olderMat),
    .headFlat (headFlat),
    .unitBusy (unitBusy),
    .strobe   (strobe)
  );

  issueGrantReg #(
    .ENTRIES  (ENTRIES),
    .PORTS    (PORTS),
    .strobe_t (strobe_t)
  ) grantReg_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .grantValid (grantValid),
    .grantVec   (grantVec)
  );

endmodule

// File: rtl/issueSelectChecker.sv
module issueSelectChecker
  import issuePkg::*;
#(
  parameter int        ENTRIES = 8,
  parameter int        PORTS   = 2,
  parameter int        HEAD_W  = 2,
  parameter issueOrg_e ORG     = ORG_UNIFIED
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [ENTRIES-1:0]       readyVec,
  input logic [PORTS*HEAD_W-1:0]  headFlat,
  input logic [PORTS-1:0]         unitBusy,
  input logic [PORTS-1:0]         grantValid,
  input logic [PORTS*ENTRIES-1:0] grantVec
);

  localparam int BANK = ENTRIES / PORTS;

  logic unusedChk;
  assign unusedChk = ^headFlat;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (grantValid == '0 && grantVec == '0));

  assert_valid_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantValid) <= $countones($past(readyVec)));

  for (genvar p = 0; p < PORTS; p++) begin : gPort
    assert_port_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantVec[p*ENTRIES +: ENTRIES]) &&
      (grantValid[p] == (grantVec[p*ENTRIES +: ENTRIES] != '0)));

    assert_busy_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
      $past(unitBusy[p]) |-> !grantValid[p]);

    if (ORG != ORG_UNIFIED) begin : gBankOnly
      for (genvar e = 0; e < ENTRIES; e++) begin : gOut
        if (e / BANK != p) begin : gForeign
          assert_bank_confined_R7: assert property (@(posedge clk) disable iff (!rstN)
            !grantVec[p*ENTRIES+e]);
        end
      end
    end

    if (ORG == ORG_FIFO) begin : gHead
      assert_head_only_R8: assert property (@(posedge clk) disable iff (!rstN)
        grantValid[p] |-> grantVec[p*ENTRIES +: ENTRIES] ==
          (ENTRIES'(1) << (p*BANK + int'($past(headFlat[p*HEAD_W +: HEAD_W])))));
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic [PORTS-1:0] column;
    for (genvar p = 0; p < PORTS; p++) begin : gBit
      assign column[p] = grantVec[p*ENTRIES+e];
    end

    assert_single_port_R4: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(column));

    assert_ready_only_R4: assert property (@(posedge clk) disable iff (!rstN)
      (column != '0) |-> $past(readyVec[e]));
  end

endmodule

bind issueSelect issueSelectChecker #(
  .ENTRIES (ENTRIES),
  .PORTS   (PORTS),
  .HEAD_W  (HEAD_W),
  .ORG     (ORG)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .readyVec   (readyVec),
  .headFlat   (headFlat),
  .unitBusy   (unitBusy),
  .grantValid (grantValid),
  .grantVec   (grantVec)
);

// File: tb/issueSelect_tb.sv
`timescale 1ns/1ps
module issueSelect_tb_top;
  import issuePkg::*;

  localparam int E  = 8;
  localparam int P  = 2;
  localparam int AW = 4;
  localparam int B  = E / P;
  localparam int HW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [E-1:0]    ready;
  logic [AW-1:0]   age  [E];
  logic [HW-1:0]   head [P];
  logic [P-1:0]    busy;
  logic [E*AW-1:0] ageFlat;
  logic [P*HW-1:0] headFlat;

  for (genvar e = 0; e < E; e++) begin : gAge
    assign ageFlat[e*AW +: AW] = age[e];
  end
  for (genvar b = 0; b < P; b++) begin : gHead
    assign headFlat[b*HW +: HW] = head[b];
  end

  logic [P-1:0] uV, bV, fV;
  logic [P*E-1:0] uVec, bVec, fVec;

  issueSelect #(.ENTRIES(E), .PORTS(P), .AGE_W(AW), .ORG(ORG_UNIFIED)) dut_i (
    .clk(clk), .rstN(rstN), .readyVec(ready), .ageFlat(ageFlat), .headFlat(headFlat),
    .unitBusy(busy), .grantValid(uV), .grantVec(uVec));
  issueSelect #(.ENTRIES(E), .PORTS(P), .AGE_W(AW), .ORG(ORG_BANKED)) dutBank_i (
    .clk(clk), .rstN(rstN), .readyVec(ready), .ageFlat(ageFlat), .headFlat(headFlat),
    .unitBusy(busy), .grantValid(bV), .grantVec(bVec));
  issueSelect #(.ENTRIES(E), .PORTS(P), .AGE_W(AW), .ORG(ORG_FIFO)) dutFifo_i (
    .clk(clk), .rstN(rstN), .readyVec(ready), .ageFlat(ageFlat), .headFlat(headFlat),
    .unitBusy(busy), .grantValid(fV), .grantVec(fVec));

  int checks = 0;
  int fails  = 0;

  // Models built from the requirements.
  function automatic logic [P*E-1:0] expUnified();
    logic [P*E-1:0] res = '0;
    logic [E-1:0] taken = '0;
    for (int p = 0; p < P; p++) begin
      if (!busy[p]) begin
        int best = -1;
        for (int e = 0; e < E; e++)
          if (ready[e] && !taken[e] && (best < 0 || age[e] < age[best])) best = e;
        if (best >= 0) begin
          res[p*E+best] = 1'b1;
          taken[best] = 1'b1;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [P*E-1:0] expBanked();
    logic [P*E-1:0] res = '0;
    for (int b = 0; b < P; b++) begin
      if (!busy[b]) begin
        int best = -1;
        for (int e = b*B; e < b*B+B; e++)
          if (ready[e] && (best < 0 || age[e] < age[best])) best = e;
        if (best >= 0) res[b*E+best] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [P*E-1:0] expFifo();
    logic [P*E-1:0] res = '0;
    for (int b = 0; b < P; b++)
      if (!busy[b] && ready[b*B + int'(head[b])]) res[b*E + b*B + int'(head[b])] = 1'b1;
    return res;
  endfunction

  task automatic checkOne(string tag, logic [P-1:0] gv, logic [P*E-1:0] gvec,
                          logic [P*E-1:0] expVec);
    logic [P-1:0] expV;
    for (int p = 0; p < P; p++) expV[p] = |expVec[p*E +: E];
    checks++;
    if (gv !== expV || gvec !== expVec) begin
      fails++;
      $display("FAIL %s: got valid=%b grants=%h, expected valid=%b grants=%h",
               tag, gv, gvec, expV, expVec);
    end
  endtask

  // R3/R4 structure check on the unified instance.
  task automatic checkShape(string tag);
    logic ok = 1'b1;
    logic [E-1:0] seen = '0;
    for (int p = 0; p < P; p++) begin
      if ($countones(uVec[p*E +: E]) > 1) ok = 1'b0;
      if (uV[p] != (uVec[p*E +: E] != '0)) ok = 1'b0;
      if ((seen & uVec[p*E +: E]) != '0) ok = 1'b0;
      seen |= uVec[p*E +: E];
    end
    if ((seen & ~ready) != '0) ok = 1'b0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got valid=%b grants=%h, expected one-hot, distinct, ready-only",
               tag, uV, uVec);
    end
  endtask

  // Inputs were set at the falling edge; results are due just after the next rising edge.
  task automatic settle(string tU, string tB, string tF);
    @(posedge clk);
    #1;
    checkOne(tU, uV, uVec, expUnified());
    checkOne(tB, bV, bVec, expBanked());
    checkOne(tF, fV, fVec, expFifo());
  endtask

  task automatic setAll(logic [E-1:0] r, logic [P-1:0] bz);
    ready = r;
    busy  = bz;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish, expected end of test");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [P*E-1:0] holdU;
    void'($urandom(32'd2024));
    ready = '1;
    busy  = '0;
    for (int e = 0; e < E; e++) age[e] = AW'(E - 1 - e);
    for (int b = 0; b < P; b++) head[b] = '0;

    // R1: inputs would grant, but reset holds outputs at zero.
    repeat (2) @(posedge clk);
    #1;
    checkOne("R1 reset unified", uV, uVec, '0);
    checkOne("R1 reset banked", bV, bVec, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R6: distinct ages, entry 7 oldest -> port0=7, port1=6.
    settle("R6 unified distinct ages", "R7 banked distinct ages", "R8 head-only base");

    // R2: a change between edges leaves outputs unchanged until the next edge.
    holdU = uVec;
    @(negedge clk);
    setAll(8'b0000_0001, 2'b00);
    #1;
    checkOne("R2 latency hold", uV, uVec, holdU);
    settle("R2 unified after edge", "R2 banked after edge", "R2 head-only after edge");

    // R6: equal ages, lower index wins.
    @(negedge clk);
    for (int e = 0; e < E; e++) age[e] = 4'd5;
    setAll('1, 2'b00);
    settle("R6 unified tie by index", "R7 banked tie by index", "R8 head-only tie");

    // R5: port0 busy -> unified oldest moves to port1, bank0 held.
    @(negedge clk);
    setAll('1, 2'b01);
    settle("R5 unified port0 busy", "R5 banked port0 busy", "R5 head-only port0 busy");

    // R5: everything busy.
    @(negedge clk);
    setAll('1, 2'b11);
    settle("R5 unified all busy", "R5 banked all busy", "R5 head-only all busy");

    // R9: one ready entry, two free ports.
    @(negedge clk);
    setAll(8'b0000_1000, 2'b00);
    settle("R9 unified single ready", "R9 banked single ready", "R9 head-only single ready");

    // R8: head of bank0 not ready though its neighbours are.
    @(negedge clk);
    for (int e = 0; e < E; e++) age[e] = AW'(e);
    head[0] = 2'd1;
    head[1] = 2'd2;
    setAll(8'b0100_1101, 2'b00);
    settle("R6 unified mixed", "R7 banked mixed", "R8 head-only head not ready");

    // R9: nothing ready.
    @(negedge clk);
    setAll('0, 2'b00);
    settle("R9 unified none ready", "R9 banked none ready", "R9 head-only none ready");

    // Random traffic.
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ready = E'($urandom);
      for (int e = 0; e < E; e++) age[e] = AW'($urandom % 16);
      for (int b = 0; b < P; b++) head[b] = HW'($urandom % B);
      for (int p = 0; p < P; p++) busy[p] = ($urandom % 4) == 0;
      settle("R6 unified random", "R7 banked random", "R8 head-only random");
      checkShape("R3 R4 unified shape");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule